// File: doc/BRIEF.md
# Ballast Power Mode Sequencer

This block sequences the supply states of a gate-driver companion chip for a microcontrolled lamp ballast. It has four modes: power-up charging, a low-power standby, full run, and a fault hold. Analog comparators outside the block reduce the supply and reference levels to flags, and the half-bridge logic inputs are sampled each clock. The registered outputs switch the high-voltage start-up source, the reference (off, low-current or high-current), the pull-down that holds the reference low while it is off, the supply regulator, the over-current detector and the gate drivers.

Entry to run mode is guarded. Standby must have lasted a settle window, the reference-good flag must be set, and the high-side input must show a falling edge. In run mode a watchdog watches the low-side input for edges and drops the block back to standby when it stays idle too long. Both windows are set as microsecond parameters and converted to clock cycles from the clock frequency parameter. Every output and the mode code change on the clock edge after the inputs that cause them.

Top module: `pwr_mode_seq`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block in power-up mode (code 0) with every enable output low.
- R2: In power-up mode the start-up source and the reference pull-down are on, and all other enables are off. A set `sup_on_i` moves the block to standby.
- R3: In standby the reference is on at low current (`ref_hi_o` low). The start-up source turns on while `sup_save_i` is clear and turns off when `sup_on_i` is set. Between the two it keeps its previous value.
- R4: Standby moves to run only when all three conditions hold: at least SETTLE_US x CLK_MHZ cycles have been spent in standby, `ref_good_i` is set, and `hs_in_i` falls (high on the previous cycle, low now).
- R5: In run mode the start-up source and the pull-down are off, the reference is on at high current, and the regulator, over-current detector and drivers are on.
- R6: In run mode, TIMEOUT_US x CLK_MHZ consecutive cycles without a change on `ls_in_i` return the block to standby. Any change restarts the count.
- R7: Run mode moves to fault hold when `sup_uvlo_i` or `ref_ok_i` is clear. This exit takes priority over the idle timeout.
- R8: In fault hold the start-up source and the low-current reference are on, and the regulator, over-current detector, drivers and pull-down are off. A set `sup_on_i` moves it to standby.
- R9: From standby or fault hold, a clear `sup_refoff_i` returns the block to power-up. This exit takes priority over every other exit from those modes.
- R10: `mode_o` encodes the current mode as 0 power-up, 1 standby, 2 run, 3 fault hold.
- R11: The reference output and the reference pull-down are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sup_on_i | input | 1 | Supply at or above the turn-on level |
| sup_save_i | input | 1 | Supply at or above the standby regulation level |
| sup_uvlo_i | input | 1 | Supply at or above the undervoltage level |
| sup_refoff_i | input | 1 | Supply at or above the reference shut-off level |
| ref_good_i | input | 1 | Reference above the run-entry level |
| ref_ok_i | input | 1 | Reference above the fault level |
| hs_in_i | input | 1 | High-side half-bridge logic input |
| ls_in_i | input | 1 | Low-side half-bridge logic input |
| hv_src_en_o | output | 1 | Enable of the high-voltage start-up source |
| ref_en_o | output | 1 | Reference output enable |
| ref_hi_o | output | 1 | Reference in high-current mode |
| ref_sink_en_o | output | 1 | Reference pull-down enable |
| reg_en_o | output | 1 | Supply regulator enable |
| ocp_en_o | output | 1 | Over-current detector enable |
| drv_en_o | output | 1 | Gate driver enable |
| mode_o | output | 2 | Current mode code |

## Verification
The bench first sends a falling high-side edge during the settle window and another while `ref_good_i` is clear. A sequencer that checked only the edge would enter run mode early on either one. It then toggles the low-side input at intervals shorter than the timeout before letting it go idle. A counter that failed to restart on edges would fall out of run mode while switching was still active. The start-up source hysteresis is exercised from both sides of the band, which exposes a design that follows only one flag. The power-up exit is forced at the same moment as a valid run-entry edge. A design with the wrong priority would enter run mode instead of returning to power-up.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

    typedef enum logic [1:0] {
        PM_START = 2'd0,
        PM_SAVE  = 2'd1,
        PM_RUN   = 2'd2,
        PM_FAULT = 2'd3
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e mode;
        logic     hv;
        logic     ref_on;
        logic     ref_hi;
        logic     sink;
        logic     reg_on;
        logic     ocp;
        logic     drv;
    } pm_reg_t;

    localparam pm_reg_t PM_RESET = '{mode: PM_START, default: 1'b0};

endpackage

// File: rtl/pmseq_edge.sv
module pmseq_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] chg_o
);
    logic [N-1:0] prev_d, prev_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        assign fall_o[b] = prev_q[b] & ~sig_i[b];
        assign chg_o[b]  = prev_q[b] ^ sig_i[b];
    end

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/pmseq_span.sv
module pmseq_span #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)        cnt_d = '0;
        else if (!done_o) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    a_r4_span_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pmseq_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int SETTLE_US  = 10,
    parameter int TIMEOUT_US = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sup_on_i,
    input  logic       sup_save_i,
    input  logic       sup_uvlo_i,
    input  logic       sup_refoff_i,
    input  logic       ref_good_i,
    input  logic       ref_ok_i,
    input  logic       hs_in_i,
    input  logic       ls_in_i,
    output logic       hv_src_en_o,
    output logic       ref_en_o,
    output logic       ref_hi_o,
    output logic       ref_sink_en_o,
    output logic       reg_en_o,
    output logic       ocp_en_o,
    output logic       drv_en_o,
    output logic [1:0] mode_o
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int IDLE_CYC   = CLK_MHZ * TIMEOUT_US;

    pm_reg_t    st_d, st_q;
    logic [1:0] fall, chg;
    logic       hs_fall, ls_chg, settle_done, idle_done;

    pmseq_edge #(.N(2)) i_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  ({ls_in_i, hs_in_i}),
        .fall_o (fall),
        .chg_o  (chg)
    );
    assign hs_fall = fall[0];
    assign ls_chg  = chg[1];

    pmseq_span #(.LIMIT(SETTLE_CYC)) i_settle (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (st_q.mode != PM_SAVE),
        .done_o (settle_done)
    );

    pmseq_span #(.LIMIT(IDLE_CYC)) i_idle (
        .clk    (clk),
        .rst    (rst),
        .clr_i  ((st_q.mode != PM_RUN) || ls_chg),
        .done_o (idle_done)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PM_START: if (sup_on_i) st_d.mode = PM_SAVE;
            PM_SAVE: begin
                if (!sup_refoff_i)                             st_d.mode = PM_START;
                else if (settle_done && ref_good_i && hs_fall) st_d.mode = PM_RUN;
            end
            PM_RUN: begin
                if (!sup_uvlo_i || !ref_ok_i) st_d.mode = PM_FAULT;
                else if (idle_done)           st_d.mode = PM_SAVE;
            end
            PM_FAULT: begin
                if (!sup_refoff_i) st_d.mode = PM_START;
                else if (sup_on_i) st_d.mode = PM_SAVE;
            end
            default: st_d.mode = PM_START;
        endcase

        st_d.ref_on = (st_d.mode != PM_START);
        st_d.sink   = (st_d.mode == PM_START);
        st_d.ref_hi = (st_d.mode == PM_RUN);
        st_d.reg_on = (st_d.mode == PM_RUN);
        st_d.ocp    = (st_d.mode == PM_RUN);
        st_d.drv    = (st_d.mode == PM_RUN);

        unique case (st_d.mode)
            PM_START, PM_FAULT: st_d.hv = 1'b1;
            PM_RUN:             st_d.hv = 1'b0;
            default: begin
                if (sup_on_i)         st_d.hv = 1'b0;
                else if (!sup_save_i) st_d.hv = 1'b1;
                else                  st_d.hv = st_q.hv;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PM_RESET;
        else     st_q <= st_d;
    end

    assign hv_src_en_o   = st_q.hv;
    assign ref_en_o      = st_q.ref_on;
    assign ref_hi_o      = st_q.ref_hi;
    assign ref_sink_en_o = st_q.sink;
    assign reg_en_o      = st_q.reg_on;
    assign ocp_en_o      = st_q.ocp;
    assign drv_en_o      = st_q.drv;
    assign mode_o        = st_q.mode;

    // R2: power-up leaves on the turn-on flag
    a_r2_leave_start: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == PM_START && sup_on_i) |=> (mode_o == PM_SAVE));

    // R3: start-up source is off once turn-on is reached in standby
    a_r3_hv_stop: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == PM_SAVE && sup_on_i && sup_refoff_i) |=> !hv_src_en_o);

    // R4: run is only entered from a qualified standby
    a_r4_run_entry: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == PM_SAVE && mode_o == PM_SAVE && !(settle_done && ref_good_i && hs_fall))
        |=> (mode_o != PM_RUN));

    // R6: idle low-side input returns run to standby
    a_r6_idle_exit: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == PM_RUN && idle_done && sup_uvlo_i && ref_ok_i) |=> (mode_o == PM_SAVE));

    // R7: supply or reference fault in run goes to fault hold
    a_r7_fault: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == PM_RUN && (!sup_uvlo_i || !ref_ok_i)) |=> (mode_o == PM_FAULT));

    // R9: low supply in standby or fault hold returns to power-up
    a_r9_refoff: assert property (@(posedge clk) disable iff (rst)
        ((st_q.mode == PM_SAVE || st_q.mode == PM_FAULT) && !sup_refoff_i)
        |=> (mode_o == PM_START));

    // R11: reference and its pull-down never fight
    a_r11_no_fight: assert property (@(posedge clk) disable iff (rst)
        !(ref_en_o && ref_sink_en_o));
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
    localparam int S = 10;
    localparam int T = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic on_f = 0, save_f = 0, uvlo_f = 0, refoff_f = 0, rgood = 0, rok = 0, hs = 0, ls = 0;
    logic hv, ren, rhi, sink, regen, ocp, drv;
    logic [1:0] mode;

    int vectors = 0;
    int errors  = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    pwr_mode_seq #(.CLK_MHZ(1), .SETTLE_US(10), .TIMEOUT_US(100)) i_pwr_mode_seq (
        .clk(clk), .rst(rst),
        .sup_on_i(on_f), .sup_save_i(save_f), .sup_uvlo_i(uvlo_f), .sup_refoff_i(refoff_f),
        .ref_good_i(rgood), .ref_ok_i(rok), .hs_in_i(hs), .ls_in_i(ls),
        .hv_src_en_o(hv), .ref_en_o(ren), .ref_hi_o(rhi), .ref_sink_en_o(sink),
        .reg_en_o(regen), .ocp_en_o(ocp), .drv_en_o(drv), .mode_o(mode)
    );

    // behavioural reference model
    int m_mode = 0, m_in_save = 0, m_idle = 0;
    bit m_hv = 0, m_rst = 1, p_hs = 0, p_ls = 0;

    always @(posedge clk) begin
        int nxt;
        bit hs_fall, ls_chg;
        logic [6:0] exp_en, got_en;
        if (rst) begin
            m_mode = 0; m_in_save = 0; m_idle = 0; m_hv = 0; m_rst = 1; p_hs = 0; p_ls = 0;
        end else begin
            hs_fall = p_hs && !hs;
            ls_chg  = (p_ls != ls);
            nxt = m_mode;
            if (m_mode == 0) begin
                if (on_f) nxt = 1;
            end else if (m_mode == 1) begin
                if (!refoff_f) nxt = 0;
                else if (m_in_save >= S && rgood && hs_fall) nxt = 2;
            end else if (m_mode == 2) begin
                if (!uvlo_f || !rok) nxt = 3;
                else if (m_idle >= T) nxt = 1;
            end else begin
                if (!refoff_f) nxt = 0;
                else if (on_f) nxt = 1;
            end
            m_in_save = (m_mode == 1) ? ((m_in_save < S) ? m_in_save + 1 : S) : 0;
            m_idle = (m_mode == 2 && !ls_chg) ? ((m_idle < T) ? m_idle + 1 : T) : 0;
            if (nxt == 0 || nxt == 3) m_hv = 1;
            else if (nxt == 2) m_hv = 0;
            else if (on_f) m_hv = 0;
            else if (!save_f) m_hv = 1;
            m_mode = nxt;
            m_rst = 0;
            p_hs = hs;
            p_ls = ls;
        end
        #2;
        if (m_rst) exp_en = 7'b0;
        else exp_en = {m_hv, m_mode != 0, m_mode == 2, m_mode == 0,
                       m_mode == 2, m_mode == 2, m_mode == 2};
        got_en = {hv, ren, rhi, sink, regen, ocp, drv};
        vectors++;
        if (got_en !== exp_en) begin
            errors++;
            $display("FAIL %s enables got %b exp %b at %0t", tag, got_en, exp_en, $time);
        end
        vectors++;
        if (mode !== 2'(m_mode)) begin
            errors++;
            $display("FAIL R10 mode got %0d exp %0d at %0t", mode, m_mode, $time);
        end
        vectors++;
        if (ren && sink) begin
            errors++;
            $display("FAIL R11 ref/sink got %b%b exp not both 1", ren, sink);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hs_pulse();
        hs = 1'b1; step(1);
        hs = 1'b0; step(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got hang exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        tag = "R1"; step(3);
        rst = 1'b0;
        tag = "R2"; step(4);
        refoff_f = 1; step(3);
        on_f = 1; save_f = 1; uvlo_f = 1; rgood = 1; rok = 1; step(2);
        tag = "R4"; hs_pulse();                     // edge inside settle window
        tag = "R3";
        on_f = 0; step(3);
        save_f = 0; step(3);
        save_f = 1; step(3);
        on_f = 1; step(3);
        tag = "R4"; step(5);
        rgood = 0; hs_pulse();                      // reference not good
        rgood = 1; hs_pulse();                      // qualified entry
        tag = "R5"; step(3);
        tag = "R6";
        for (int k = 0; k < 15; k++) begin ls = ~ls; step(20); end
        step(130);
        tag = "R4"; step(12); hs_pulse();
        tag = "R7"; ls = ~ls; rok = 0; step(3);
        rok = 1;
        tag = "R8"; on_f = 0; step(4);
        on_f = 1; step(3);
        tag = "R9"; step(12);
        hs = 1; step(1);
        refoff_f = 0; hs = 0; step(3);              // refoff beats a valid edge
        refoff_f = 1; step(3);
        step(12); hs_pulse();
        tag = "R7"; uvlo_f = 0; step(3);
        tag = "R9"; on_f = 0; refoff_f = 0; step(3);
        tag = "R1"; rst = 1; step(2);
        rst = 0; step(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule